// File: doc/BRIEF.md
# Multi-Source Down/Up Timer Channel

This block is one 16-bit timer channel. It has three operating modes. In the free timer mode it counts down on an internally prescaled clock enable. In the event mode it counts down on rising edges of an external pin, or on the underflow strobe of a neighbouring channel. In the measurement mode it counts up on a prescaled enable and captures the time between edges of the external pin. The pin is synchronised and then passes a majority-free noise filter: a new level is accepted only after three equal consecutive samples.

The channel makes its own prescaled enables from the system clock. These are a base enable (the full clock, or the clock divided by two), the clock divided by 8, and the clock divided by 32. A fourth enable is a slow sub-clock tick input divided by 32. A prescaler-reset input clears every divider so that all the enables restart in a known phase. Each time the channel underflows, or a measurement completes, it raises a one-cycle interrupt pulse. It also drives an underflow/overflow strobe that a neighbouring channel can use as its event source. Register decoding is left to the surrounding logic: the configuration arrives as plain ports, and two one-cycle write strobes mark the reload and mode writes.

Top module: `mtimer_chan`

## Requirements
- R1: After reset, count_o, capture_o, ovf_o, irq_o and uf_o are all zero.
- R2: In timer mode (mode_i=00), clk_sel_i picks the count enable. The codes are 00 for the base enable, 01 for clock/8, 10 for clock/32 and 11 for sub_clk_en_i/32. The base enable is every cycle when pclk_full_i=1 and every second cycle when pclk_full_i=0. With reload value R, successive interrupts are therefore (R+1) times the enable period apart.
- R3: In timer and event modes, a tick at count zero reloads the count from the reload register. In the same cycle it raises irq_o and uf_o, each for exactly one cycle.
- R4: While start_i=0 the count holds its value. A reload_wr_i strobe while start_i=0 also loads reload_val_i into the count.
- R5: In event mode (mode_i=01) with clk_sel_i[1]=1, each one-cycle pulse on chain_i decrements the count by one.
- R6: In event mode with clk_sel_i[1]=0, each rising edge of the filtered ext_pin_i decrements the count by one. The filter samples on the base enable. A pin pulse that lasts fewer than 3 samples is ignored.
- R7: In measurement mode (mode_i=10) with width_sel_i=0, each filtered rising edge copies the running count to capture_o, clears the count and pulses irq_o. When the count advances every cycle, a pin period of P cycles captures P-1. capture_o changes in no other mode.
- R8: In measurement mode with width_sel_i=1, a filtered rising edge clears the count and a filtered falling edge captures it and pulses irq_o. A high time of H cycles captures H-1.
- R9: In measurement mode, a count that wraps past 16'hFFFF sets ovf_o. ovf_o stays set until a mode_wr_i strobe clears it.
- R10: While presc_rst_i=1 the clock/8, clock/32 and sub-clock enables are held off. After release, the first clock/8 tick advances the count at the 8th clock edge.
- R11: Mode code 11 is reserved. The count holds its value and irq_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Counting enable |
| mode_i | input | 2 | 00 timer, 01 event, 10 measurement, 11 reserved |
| clk_sel_i | input | 2 | Count source select |
| pclk_full_i | input | 1 | Base enable every cycle (1) or every second cycle (0) |
| width_sel_i | input | 1 | Measurement: 0 period, 1 high width |
| reload_val_i | input | 16 | Value for a reload write |
| reload_wr_i | input | 1 | One-cycle reload write strobe |
| mode_wr_i | input | 1 | One-cycle mode write strobe, clears ovf_o |
| presc_rst_i | input | 1 | Prescaler divider reset |
| sub_clk_en_i | input | 1 | Slow sub-clock tick, one cycle wide |
| ext_pin_i | input | 1 | External input pin, asynchronous |
| chain_i | input | 1 | Underflow strobe of a neighbouring channel |
| count_o | output | 16 | Current counter value |
| capture_o | output | 16 | Last measured value |
| ovf_o | output | 1 | Sticky measurement overflow flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| uf_o | output | 1 | Underflow/overflow strobe for chaining |

## Verification
The hardest state to reach is the sticky measurement overflow. The counter has to run through all 65536 values without a single filtered edge. The bench holds the pin quiet, selects the every-cycle base enable and waits past the wrap before it checks the flag and clears it with a mode write. Two other cases are just as deliberate. For glitch rejection, the bench drives a two-cycle pin pulse and compares the count against a long pulse. For the prescaler phase, the bench holds the divider reset with the channel already running and counts edges after release.

// File: rtl/mtimer_pkg.sv
// Package: shared mode encoding and count-source codes for the timer channel.
// Assumes: the 2-bit mode field and the 2-bit source field are decoded only here.
package mtimer_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_MEAS  = 2'b10,
        MODE_RSVD  = 2'b11
    } tmr_mode_e;

    localparam logic [1:0] SRC_BASE = 2'b00;
    localparam logic [1:0] SRC_DIV8 = 2'b01;
    localparam logic [1:0] SRC_DIV32 = 2'b10;
    localparam logic [1:0] SRC_SUB = 2'b11;

endpackage

// File: rtl/mtimer_prescaler.sv
// Module: mtimer_prescaler
// Derives one-cycle count enables from the system clock and the sub-clock tick.
// Assumes: all divide ratios are powers of two; presc_rst_i clears every divider.
module mtimer_prescaler #(
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 4,
    parameter int DIV_SUB  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic presc_rst_i,
    input  logic pclk_full_i,
    input  logic sub_clk_en_i,
    output logic en_base_o,
    output logic en_mid_o,
    output logic en_slow_o,
    output logic en_sub_o
);

    localparam int MID_W  = (DIV_MID  > 2) ? $clog2(DIV_MID)  : 1;
    localparam int SLOW_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
    localparam int SUB_W  = (DIV_SUB  > 2) ? $clog2(DIV_SUB)  : 1;
    localparam logic [MID_W-1:0]  MID_LAST  = MID_W'(DIV_MID - 1);
    localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(DIV_SLOW - 1);
    localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(DIV_SUB - 1);

    logic [MID_W-1:0]  mid_q;
    logic [SLOW_W-1:0] slow_q;
    logic [SUB_W-1:0]  sub_q;

    // Decode the enables from the divider states.
    always_comb begin
        en_base_o = pclk_full_i | mid_q[0];
        en_mid_o  = (mid_q == MID_LAST);
        en_slow_o = en_mid_o && (slow_q == SLOW_LAST);
        en_sub_o  = sub_clk_en_i && (sub_q == SUB_LAST);
    end

    // Advance the dividers, or restart them all together.
    always_ff @(posedge clk) begin
        if (!rst_n || presc_rst_i) begin
            mid_q  <= '0;
            slow_q <= '0;
            sub_q  <= '0;
        end else begin
            mid_q <= mid_q + 1'b1;
            if (en_mid_o) begin
                slow_q <= slow_q + 1'b1;
            end
            if (sub_clk_en_i) begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        presc_rst_i |=> (!en_mid_o && !en_slow_o && !en_sub_o)); // R10

endmodule

// File: rtl/mtimer_filter.sv
// Module: mtimer_filter
// Synchronises the pin and accepts a new level only after FILT_LEN equal samples.
// Assumes: en_i is a one-cycle sample enable; rise_o/fall_o are one-cycle pulses.
module mtimer_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic [FILT_LEN-1:0]    hist_nx;
    logic                   all_hi;
    logic                   all_lo;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
        end
    end

    // Form the sample history that the next enable would store.
    always_comb begin
        hist_nx = {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        all_hi  = &hist_nx;
        all_lo  = ~|hist_nx;
    end

    // Shift in a sample per enable and switch level on a full agreeing run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '0;
            level_o <= 1'b0;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end else begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if (en_i) begin
                hist_q <= hist_nx;
                if (all_hi && !level_o) begin
                    level_o <= 1'b1;
                    rise_o  <= 1'b1;
                end else if (all_lo && level_o) begin
                    level_o <= 1'b0;
                    fall_o  <= 1'b1;
                end
            end
        end
    end

    AST_FILT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> $past(en_i)); // R6
    AST_FILT_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o)); // R6

endmodule

// File: rtl/mtimer_counter.sv
// Module: mtimer_counter
// Holds the counter, reload and capture registers and applies the mode behaviour.
// Assumes: tick_i, rise_i and fall_i are one-cycle pulses already chosen by the top.
module mtimer_counter
    import mtimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode_i,
    input  logic             start_i,
    input  logic             width_sel_i,
    input  logic             tick_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             reload_wr_i,
    input  logic             mode_wr_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             ovf_o,
    output logic             irq_o,
    output logic             uf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] reload_q;
    logic             cap_edge;
    logic             clr_edge;

    // Pick the edge that ends a measurement and the one that only starts it.
    always_comb begin
        cap_edge = width_sel_i ? fall_i : rise_i;
        clr_edge = width_sel_i & rise_i;
    end

    // Update count, reload, capture and the status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q  <= '0;
            count_o   <= '0;
            capture_o <= '0;
            ovf_o     <= 1'b0;
            irq_o     <= 1'b0;
            uf_o      <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            uf_o  <= 1'b0;
            if (mode_wr_i) begin
                ovf_o <= 1'b0;
            end
            if (reload_wr_i) begin
                reload_q <= reload_val_i;
                if (!start_i) begin
                    count_o <= reload_val_i;
                end
            end
            if (start_i) begin
                unique case (mode_i)
                    MODE_TIMER, MODE_EVENT: begin
                        if (tick_i) begin
                            if (count_o == '0) begin
                                count_o <= reload_q;
                                irq_o   <= 1'b1;
                                uf_o    <= 1'b1;
                            end else begin
                                count_o <= count_o - 1'b1;
                            end
                        end
                    end
                    MODE_MEAS: begin
                        if (cap_edge) begin
                            capture_o <= count_o;
                            count_o   <= '0;
                            irq_o     <= 1'b1;
                        end else if (clr_edge) begin
                            count_o <= '0;
                        end else if (tick_i) begin
                            count_o <= count_o + 1'b1;
                            if (count_o == CNT_MAX) begin
                                ovf_o <= 1'b1;
                                uf_o  <= 1'b1;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !reload_wr_i) |=> $stable(count_o)); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !mode_wr_i) |=> ovf_o); // R9
    AST_CAP_MEAS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_MEAS) |=> $stable(capture_o)); // R7
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RSVD) |=> !irq_o); // R11

endmodule

// File: rtl/mtimer_chan.sv
// Module: mtimer_chan
// Timer channel top: prescaler, pin filter, source selection and counter.
// Assumes: configuration ports are static between the write strobes.
module mtimer_chan
    import mtimer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_MID     = 8,
    parameter int DIV_SLOW    = 4,
    parameter int DIV_SUB     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       clk_sel_i,
    input  logic             pclk_full_i,
    input  logic             width_sel_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             reload_wr_i,
    input  logic             mode_wr_i,
    input  logic             presc_rst_i,
    input  logic             sub_clk_en_i,
    input  logic             ext_pin_i,
    input  logic             chain_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             ovf_o,
    output logic             irq_o,
    output logic             uf_o
);

    tmr_mode_e mode;
    logic      en_base;
    logic      en_mid;
    logic      en_slow;
    logic      en_sub;
    logic      sel_en;
    logic      filt_en;
    logic      filt_level;
    logic      filt_rise;
    logic      filt_fall;
    logic      tick;

    // Map the raw mode field onto the shared encoding.
    always_comb begin
        mode = tmr_mode_e'(mode_i);
    end

    mtimer_prescaler #(
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW),
        .DIV_SUB  (DIV_SUB)
    ) i_prescaler (
        .clk          (clk),
        .rst_n        (rst_n),
        .presc_rst_i  (presc_rst_i),
        .pclk_full_i  (pclk_full_i),
        .sub_clk_en_i (sub_clk_en_i),
        .en_base_o    (en_base),
        .en_mid_o     (en_mid),
        .en_slow_o    (en_slow),
        .en_sub_o     (en_sub)
    );

    // Choose the internal enable named by the source field.
    always_comb begin
        unique case (clk_sel_i)
            SRC_BASE:  sel_en = en_base;
            SRC_DIV8:  sel_en = en_mid;
            SRC_DIV32: sel_en = en_slow;
            default:   sel_en = en_sub;
        endcase
    end

    // Sample the pin on the base enable in event mode, else on the chosen enable.
    always_comb begin
        filt_en = (mode == MODE_EVENT) ? en_base : sel_en;
    end

    mtimer_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) i_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (filt_en),
        .pin_i   (ext_pin_i),
        .level_o (filt_level),
        .rise_o  (filt_rise),
        .fall_o  (filt_fall)
    );

    // Route the count tick for the active mode.
    always_comb begin
        unique case (mode)
            MODE_TIMER, MODE_MEAS: tick = sel_en;
            MODE_EVENT:            tick = clk_sel_i[1] ? chain_i : filt_rise;
            default:               tick = 1'b0;
        endcase
    end

    mtimer_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .start_i      (start_i),
        .width_sel_i  (width_sel_i),
        .tick_i       (tick),
        .rise_i       (filt_rise),
        .fall_i       (filt_fall),
        .reload_val_i (reload_val_i),
        .reload_wr_i  (reload_wr_i),
        .mode_wr_i    (mode_wr_i),
        .count_o      (count_o),
        .capture_o    (capture_o),
        .ovf_o        (ovf_o),
        .irq_o        (irq_o),
        .uf_o         (uf_o)
    );

    AST_IRQ_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(start_i && (tick || filt_rise || filt_fall))); // R3
    AST_FILT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rise |-> filt_level); // R6

endmodule

// File: tb/test_mtimer_chan.sv
// Bench for mtimer_chan: a scoreboard queue holds the expected interrupt intervals
// and capture values, and a monitor pops and compares them at each interrupt.
module test_mtimer_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [1:0]  clk_sel_i = 2'b00;
    logic        pclk_full_i = 1'b1;
    logic        width_sel_i = 1'b0;
    logic [15:0] reload_val_i = '0;
    logic        reload_wr_i = 1'b0;
    logic        mode_wr_i = 1'b0;
    logic        presc_rst_i = 1'b0;
    logic        sub_clk_en_i = 1'b1;
    logic        ext_pin_i = 1'b0;
    logic        chain_i = 1'b0;
    logic [15:0] count_o;
    logic [15:0] capture_o;
    logic        ovf_o;
    logic        irq_o;
    logic        uf_o;

    typedef struct {
        bit    is_cap;
        int    exp;
        string req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_irq = 0;
    int irq_total = 0;
    bit prev_irq = 1'b0;
    bit gen_en = 1'b0;
    int gen_hi = 10;
    int gen_lo = 15;

    always #2 clk = ~clk;

    mtimer_chan i_mtimer_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .clk_sel_i    (clk_sel_i),
        .pclk_full_i  (pclk_full_i),
        .width_sel_i  (width_sel_i),
        .reload_val_i (reload_val_i),
        .reload_wr_i  (reload_wr_i),
        .mode_wr_i    (mode_wr_i),
        .presc_rst_i  (presc_rst_i),
        .sub_clk_en_i (sub_clk_en_i),
        .ext_pin_i    (ext_pin_i),
        .chain_i      (chain_i),
        .count_o      (count_o),
        .capture_o    (capture_o),
        .ovf_o        (ovf_o),
        .irq_o        (irq_o),
        .uf_o         (uf_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: on each interrupt pop one expected item and compare it.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && irq_o) begin
            irq_total++;
            if (prev_irq) begin
                checks++;
                errors++;
                $display("FAIL R3 actual=irq wider than 1 expected=1 cycle");
            end
            if (sb_q.size() > 0) begin
                sb_item_t it;
                int val;
                it = sb_q.pop_front();
                val = it.is_cap ? int'(capture_o) : (cyc - last_irq);
                checks++;
                if (val != it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%0d expected=%0d", it.req, val, it.exp);
                end
            end
            last_irq = cyc;
        end
        prev_irq = irq_o;
    end

    // Pin pattern generator for the measurement cases.
    initial begin
        forever begin
            @(negedge clk);
            if (gen_en) begin
                ext_pin_i = 1'b1;
                repeat (gen_hi) @(negedge clk);
                ext_pin_i = 1'b0;
                repeat (gen_lo - 1) @(negedge clk);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic wr_reload(input logic [15:0] v);
        @(negedge clk);
        reload_val_i = v;
        reload_wr_i = 1'b1;
        @(negedge clk);
        reload_wr_i = 1'b0;
    endtask

    task automatic wait_irq();
        @(negedge clk);
        while (!irq_o) @(negedge clk);
    endtask

    task automatic wait_sb_empty();
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    // Driver for R2: run timer mode and queue the expected interrupt spacing.
    task automatic run_interval(input logic [1:0] sel, input logic full, input int exp, input string req);
        @(negedge clk);
        start_i = 1'b0;
        mode_i = 2'b00;
        clk_sel_i = sel;
        pclk_full_i = full;
        wr_reload(16'd3);
        start_i = 1'b1;
        wait_irq();
        @(negedge clk);
        sb_q.push_back('{is_cap: 1'b0, exp: exp, req: req});
        wait_sb_empty();
        start_i = 1'b0;
    endtask

    task automatic pulse_chain();
        @(negedge clk);
        chain_i = 1'b1;
        @(negedge clk);
        chain_i = 1'b0;
    endtask

    initial begin
        int cnt_before;
        int irq_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 capture", int'(capture_o), 0);
        chk("R1 flags", int'({ovf_o, irq_o, uf_o}), 0);

        // R4: load while stopped, then hold
        wr_reload(16'd3);
        chk("R4 load while stopped", int'(count_o), 3);
        repeat (10) @(negedge clk);
        chk("R4 hold while stopped", int'(count_o), 3);

        // R2: interrupt spacing for every source
        run_interval(2'b00, 1'b1, 4, "R2 base full");
        run_interval(2'b00, 1'b0, 8, "R2 base half");
        run_interval(2'b01, 1'b1, 32, "R2 div8");
        run_interval(2'b10, 1'b1, 128, "R2 div32");
        run_interval(2'b11, 1'b1, 128, "R2 sub div32");

        // R5 and R3: chained event counting
        mode_i = 2'b01;
        clk_sel_i = 2'b10;
        wr_reload(16'd3);
        start_i = 1'b1;
        pulse_chain();
        chk("R5 chain step 1", int'(count_o), 2);
        pulse_chain();
        pulse_chain();
        chk("R5 chain step 3", int'(count_o), 0);
        pulse_chain();
        chk("R3 reload on underflow", int'(count_o), 3);
        chk("R3 irq and uf", int'({irq_o, uf_o}), 3);
        @(negedge clk);
        chk("R3 one-cycle pulse", int'({irq_o, uf_o}), 0);

        // R6: filtered pin events, glitch rejected
        start_i = 1'b0;
        clk_sel_i = 2'b00;
        pclk_full_i = 1'b1;
        wr_reload(16'd3);
        start_i = 1'b1;
        repeat (8) @(negedge clk);
        ext_pin_i = 1'b1;
        repeat (2) @(negedge clk);
        ext_pin_i = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 short pulse ignored", int'(count_o), 3);
        ext_pin_i = 1'b1;
        repeat (8) @(negedge clk);
        ext_pin_i = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 filtered edge counted", int'(count_o), 2);

        // R7: period measurement
        start_i = 1'b0;
        mode_i = 2'b10;
        width_sel_i = 1'b0;
        gen_hi = 10;
        gen_lo = 15;
        start_i = 1'b1;
        gen_en = 1'b1;
        wait_irq();
        @(negedge clk);
        sb_q.push_back('{is_cap: 1'b1, exp: 24, req: "R7 period capture"});
        sb_q.push_back('{is_cap: 1'b1, exp: 24, req: "R7 period capture repeat"});
        wait_sb_empty();
        gen_en = 1'b0;
        repeat (40) @(negedge clk);

        // R8: high-width measurement
        width_sel_i = 1'b1;
        gen_hi = 7;
        gen_lo = 12;
        gen_en = 1'b1;
        wait_irq();
        @(negedge clk);
        sb_q.push_back('{is_cap: 1'b1, exp: 6, req: "R8 width capture"});
        sb_q.push_back('{is_cap: 1'b1, exp: 6, req: "R8 width capture repeat"});
        wait_sb_empty();
        gen_en = 1'b0;
        repeat (40) @(negedge clk);

        // R9: sticky overflow after a full wrap with a quiet pin
        width_sel_i = 1'b0;
        chk("R9 flag clear before wrap", int'(ovf_o), 0);
        repeat (66000) @(negedge clk);
        chk("R9 flag set after wrap", int'(ovf_o), 1);
        repeat (5) @(negedge clk);
        chk("R9 flag sticky", int'(ovf_o), 1);
        mode_wr_i = 1'b1;
        @(negedge clk);
        mode_wr_i = 1'b0;
        chk("R9 cleared by mode write", int'(ovf_o), 0);

        // R10: prescaler reset holds then restarts in phase
        start_i = 1'b0;
        mode_i = 2'b00;
        clk_sel_i = 2'b01;
        wr_reload(16'd50);
        presc_rst_i = 1'b1;
        start_i = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10 held in prescaler reset", int'(count_o), 50);
        presc_rst_i = 1'b0;
        repeat (7) @(negedge clk);
        chk("R10 no tick before 8th edge", int'(count_o), 50);
        @(negedge clk);
        chk("R10 tick at 8th edge", int'(count_o), 49);

        // R11: reserved mode is quiet
        clk_sel_i = 2'b00;
        mode_i = 2'b11;
        @(negedge clk);
        cnt_before = int'(count_o);
        irq_before = irq_total;
        repeat (20) @(negedge clk);
        chk("R11 count holds", int'(count_o), cnt_before);
        chk("R11 no interrupt", irq_total, irq_before);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule